// File: doc/BRIEF.md
# Idle-Stream and Clock-Ratio Mute Detector

This block decides when an audio output path should be silenced. It watches a stream of stereo sample pairs, one pair per strobe, and the frame clock that marks each sample period. The frame clock is sampled in the system clock domain. The block counts system clock cycles between rising frame-clock edges to classify the clock ratio, and it reports whether the link runs at single or double speed.

The mute output is high in three cases. The first is reset, and the start-up interval until a supported ratio has been seen on two consecutive frame periods. The second is any time the measured ratio is unsupported or the frame clock stops. The third is after a long unbroken run of silent frames, where silent means both channel words are all zeros or all ones. A single non-silent sample on either channel lifts the mute on the next cycle.

Top module: `mute_watch`

## Requirements
- R1: While `rst_n` is low, `mute_o` is 1, `ratio_ok` is 0 and `speed_dbl` is 0.
- R2: The period is the number of `clk` cycles between consecutive rising edges of `frame_clk`. Periods of 256, 384 and 512 give `ratio_ok`=1 with `speed_dbl`=0. Periods of 128 and 192 give `ratio_ok`=1 with `speed_dbl`=1.
- R3: A period is accepted only after two consecutive full periods measure the same supported value. Until then `ratio_ok` is 0 and `mute_o` is 1. Acceptance takes effect the cycle after the third rising edge that follows reset or a clock start.
- R4: Any other period gives `ratio_ok`=0 and `mute_o`=1. So does a `frame_clk` with no rising edge for 1023 cycles.
- R5: A channel word is silent when all 24 bits are 0 or all 24 bits are 1. A strobe counts as silent only when both `smp_left` and `smp_right` are silent, and the two may differ (one all zeros, the other all ones).
- R6: While the ratio is accepted, `mute_o` rises in the cycle after the 8192nd consecutive silent strobe, and stays 0 after 8191.
- R7: A strobe with a non-silent word on either channel brings `mute_o` to 0 in the following cycle, provided the ratio is accepted.
- R8: The silent-run count saturates at 8192 and does not wrap. Any number of further silent strobes keeps `mute_o` at 1.
- R9: While the ratio is not accepted, the silent-run count is held at zero and strobes are not counted. After the ratio is accepted again, a full new run of 8192 silent strobes is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (master) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk | input | 1 | Frame clock, sampled on `clk` |
| smp_valid | input | 1 | One-cycle strobe per sample pair |
| smp_left | input | 24 | Left channel sample, two's complement |
| smp_right | input | 24 | Right channel sample, two's complement |
| mute_o | output | 1 | Mute request to the external mute stage |
| ratio_ok | output | 1 | Clock ratio accepted |
| speed_dbl | output | 1 | 1 = double-speed ratio, 0 = single-speed |

## Verification
A strobe updates the registered silent-run count at the next rising edge. Its effect on `mute_o` is therefore due one cycle later. The bench drives every strobe on a falling edge and reads `mute_o` at the next falling edge, where that effect has just landed. Ratio results change only at a rising edge of the sampled frame clock, and the first period after a change can be a mix of the old and new lengths. Ratio checks are therefore taken either at a fixed margin of ten cycles either side of the predicted third edge, or after five full periods of the new ratio. Timeout checks come 1100 cycles after the frame clock stops, past the 1023-cycle limit.

// File: rtl/mute_watch_pkg.sv
package mute_watch_pkg;

  typedef enum logic [1:0] {
    RC_NONE   = 2'd0,
    RC_SINGLE = 2'd1,
    RC_DOUBLE = 2'd2
  } ratio_class_e;

  // Map a measured clk-per-frame count to its speed class.
  function automatic ratio_class_e classify_period(input int unsigned per);
    case (per)
      32'd256, 32'd384, 32'd512: classify_period = RC_SINGLE;
      32'd128, 32'd192:          classify_period = RC_DOUBLE;
      default:                   classify_period = RC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/mute_ratio_meter.sv
module mute_ratio_meter
  import mute_watch_pkg::*;
#(
  parameter int MAX_RATIO = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_clk,
  output logic lr_rise,
  output logic locked,
  output logic dbl_mode
);
  localparam int CNT_W   = $clog2(MAX_RATIO) + 1;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic             fc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   meas;
  logic [CNT_W:0]   prev_q;
  logic             seen_q;
  logic             have_prev_q;
  logic             dbl_q;
  logic             locked_q;
  ratio_class_e     cls;
  logic             timeout;
  logic             match;

  assign lr_rise = frame_clk & ~fc_q;
  assign meas    = (CNT_W+1)'(cnt_q) + (CNT_W+1)'(1);
  assign cls     = classify_period(32'(meas));
  assign timeout = (cnt_q == CNT_W'(CNT_MAX));
  assign match   = seen_q && have_prev_q && (meas == prev_q) && (cls != RC_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_q        <= 1'b0;
      cnt_q       <= '0;
      prev_q      <= '0;
      seen_q      <= 1'b0;
      have_prev_q <= 1'b0;
      dbl_q       <= 1'b0;
      locked_q    <= 1'b0;
    end else begin
      fc_q <= frame_clk;
      if (lr_rise) begin
        cnt_q       <= '0;
        seen_q      <= 1'b1;
        have_prev_q <= seen_q;
        prev_q      <= meas;
        locked_q    <= match;
        if (match) dbl_q <= (cls == RC_DOUBLE);
      end else if (timeout) begin
        seen_q      <= 1'b0;
        have_prev_q <= 1'b0;
        locked_q    <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign locked   = locked_q;
  assign dbl_mode = locked_q & dbl_q;

endmodule

// File: rtl/mute_idle_run.sv
module mute_idle_run #(
  parameter int SMP_W    = 24,
  parameter int IDLE_RUN = 8192,
  parameter int RUN_W    = $clog2(IDLE_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_clr,
  input  logic             strobe,
  input  logic [SMP_W-1:0] left_w,
  input  logic [SMP_W-1:0] right_w,
  output logic             pair_idle,
  output logic [RUN_W-1:0] run_cnt,
  output logic             run_full
);

  function automatic logic word_silent(input logic [SMP_W-1:0] w);
    word_silent = (w == '0) || (w == '1);
  endfunction

  logic [RUN_W-1:0] cnt_q;

  assign pair_idle = word_silent(left_w) && word_silent(right_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (hold_clr) begin
      cnt_q <= '0;
    end else if (strobe) begin
      if (!pair_idle)                        cnt_q <= '0;
      else if (cnt_q != RUN_W'(IDLE_RUN))    cnt_q <= cnt_q + RUN_W'(1);
    end
  end

  assign run_cnt  = cnt_q;
  assign run_full = (cnt_q == RUN_W'(IDLE_RUN));

endmodule

// File: rtl/mute_watch.sv
module mute_watch #(
  parameter int SMP_W     = 24,
  parameter int IDLE_RUN  = 8192,
  parameter int MAX_RATIO = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_clk,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_left,
  input  logic [SMP_W-1:0] smp_right,
  output logic             mute_o,
  output logic             ratio_ok,
  output logic             speed_dbl
);
  localparam int RUN_W = $clog2(IDLE_RUN + 1);

  logic             lr_rise;
  logic             locked_w;
  logic             dbl_w;
  logic             pair_idle;
  logic [RUN_W-1:0] run_cnt;
  logic             run_full;

  mute_ratio_meter #(.MAX_RATIO(MAX_RATIO)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_clk (frame_clk),
    .lr_rise   (lr_rise),
    .locked    (locked_w),
    .dbl_mode  (dbl_w)
  );

  mute_idle_run #(.SMP_W(SMP_W), .IDLE_RUN(IDLE_RUN), .RUN_W(RUN_W)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_clr  (~locked_w),
    .strobe    (smp_valid),
    .left_w    (smp_left),
    .right_w   (smp_right),
    .pair_idle (pair_idle),
    .run_cnt   (run_cnt),
    .run_full  (run_full)
  );

  assign mute_o    = ~locked_w | run_full;
  assign ratio_ok  = locked_w;
  assign speed_dbl = dbl_w;

endmodule

// File: rtl/mute_watch_chk.sv
module mute_watch_chk #(
  parameter int IDLE_RUN = 8192,
  parameter int RUN_W    = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lr_rise,
  input logic             smp_valid,
  input logic             pair_idle,
  input logic             locked,
  input logic [RUN_W-1:0] run_cnt,
  input logic             mute_o,
  input logic             speed_dbl
);

  // R7
  release_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && locked && !pair_idle) |=> (!mute_o || !locked));

  // R8
  run_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RUN_W'(IDLE_RUN));

  // R9
  unlock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> (run_cnt == '0));

  // R3
  lock_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(lr_rise));

  // R6
  mute_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute_o) |-> (!locked || $past(smp_valid && pair_idle)));

  // R2
  speed_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(speed_dbl) |-> ($past(lr_rise) || !locked));

endmodule

bind mute_watch mute_watch_chk #(.IDLE_RUN(IDLE_RUN), .RUN_W(RUN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lr_rise   (lr_rise),
  .smp_valid (smp_valid),
  .pair_idle (pair_idle),
  .locked    (locked_w),
  .run_cnt   (run_cnt),
  .mute_o    (mute_o),
  .speed_dbl (speed_dbl)
);

// File: tb/mute_watch_test.sv
module mute_watch_test;
  localparam int W    = 24;
  localparam int RUN  = 8192;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_clk = 1'b0;
  logic smp_valid = 1'b0;
  logic [W-1:0] smp_left = '0;
  logic [W-1:0] smp_right = '0;
  logic mute_o, ratio_ok, speed_dbl;

  int lr_period = 0;
  int checks = 0;
  int fails = 0;
  int exp_cnt = 0;

  always #2.5 clk = ~clk;

  mute_watch uut (
    .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right),
    .mute_o(mute_o), .ratio_ok(ratio_ok), .speed_dbl(speed_dbl)
  );

  // Frame clock generator: period in clk cycles, 50% duty.
  initial begin
    forever begin
      if (lr_period == 0) begin
        frame_clk = 1'b0;
        @(negedge clk);
      end else begin
        int h;
        h = lr_period / 2;
        frame_clk = 1'b1;
        repeat (h) @(negedge clk);
        frame_clk = 1'b0;
        repeat (h) @(negedge clk);
      end
    end
  end

  function automatic bit exp_ok(input int p);
    return (p == 128) || (p == 192) || (p == 256) || (p == 384) || (p == 512);
  endfunction

  function automatic bit exp_dbl(input int p);
    return (p == 128) || (p == 192);
  endfunction

  function automatic bit silent(input logic [W-1:0] w);
    return (w == 0) || (w == ONES);
  endfunction

  function automatic logic [W-1:0] noisy_word();
    logic [W-1:0] w;
    w = W'($urandom);
    if (silent(w)) w = 24'h000100;
    return w;
  endfunction

  function automatic logic [W-1:0] quiet_word();
    return ($urandom % 2) ? ONES : '0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Drive one strobe, update model, check mute one cycle later.
  task automatic send(input logic [W-1:0] l, input logic [W-1:0] r, input string req);
    smp_valid = 1'b1;
    smp_left  = l;
    smp_right = r;
    @(negedge clk);
    smp_valid = 1'b0;
    if (silent(l) && silent(r)) begin
      if (exp_cnt < RUN) exp_cnt++;
    end else begin
      exp_cnt = 0;
    end
    chk(mute_o == (exp_cnt >= RUN), req, int'(mute_o), int'(exp_cnt >= RUN));
  endtask

  task automatic quiet_run(input int n, input string req);
    for (int i = 0; i < n; i++) send(quiet_word(), quiet_word(), req);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(mute_o == 1'b1, "R1 mute", int'(mute_o), 1);
    chk(ratio_ok == 1'b0, "R1 ratio_ok", int'(ratio_ok), 0);
    chk(speed_dbl == 1'b0, "R1 speed_dbl", int'(speed_dbl), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: lock only after third rising edge
    lr_period = 256;
    repeat (2*256 - 10) @(negedge clk);
    chk(ratio_ok == 1'b0, "R3 early ratio_ok", int'(ratio_ok), 0);
    chk(mute_o == 1'b1, "R3 early mute", int'(mute_o), 1);
    repeat (20) @(negedge clk);
    chk(ratio_ok == 1'b1, "R3 locked", int'(ratio_ok), 1);
    chk(mute_o == 1'b0, "R3 mute released", int'(mute_o), 0);
    chk(speed_dbl == 1'b0, "R2 256 single", int'(speed_dbl), 0);

    // R2 / R4: ratio sweep
    begin
      int plist[6] = '{128, 192, 384, 512, 300, 256};
      foreach (plist[k]) begin
        lr_period = plist[k];
        repeat (5*plist[k] + 20) @(negedge clk);
        chk(ratio_ok == exp_ok(plist[k]), exp_ok(plist[k]) ? "R2 ratio_ok" : "R4 ratio_ok",
            int'(ratio_ok), int'(exp_ok(plist[k])));
        chk(speed_dbl == exp_dbl(plist[k]), "R2 speed_dbl", int'(speed_dbl), int'(exp_dbl(plist[k])));
        chk(mute_o == !exp_ok(plist[k]), "R4 mute", int'(mute_o), int'(!exp_ok(plist[k])));
      end
    end

    // R4: frame clock stops
    lr_period = 0;
    repeat (1100) @(negedge clk);
    chk(ratio_ok == 1'b0, "R4 timeout ratio_ok", int'(ratio_ok), 0);
    chk(mute_o == 1'b1, "R4 timeout mute", int'(mute_o), 1);
    // R9: strobes while unlocked are not counted (model stays 0)
    for (int i = 0; i < 50; i++) begin
      smp_valid = 1'b1; smp_left = '0; smp_right = '0;
      @(negedge clk);
    end
    smp_valid = 1'b0;
    lr_period = 256;
    repeat (5*256) @(negedge clk);
    chk(ratio_ok == 1'b1, "R4 relock", int'(ratio_ok), 1);
    exp_cnt = 0;

    // R5: silent and non-silent word corners
    send('0, ONES, "R5 mixed silent");
    send(ONES, '0, "R5 mixed silent");
    chk(exp_cnt == 2, "R5 mixed counts", exp_cnt, 2);
    send(24'h000001, '0, "R5 lsb set");
    send('0, 24'hFFFFFE, "R5 lsb clear");
    send(24'h800000, ONES, "R5 msb only");
    send(24'h7FFFFF, '0, "R5 msb clear");

    // R6: threshold
    quiet_run(RUN - 1, "R6 below threshold");
    chk(mute_o == 1'b0, "R6 8191 no mute", int'(mute_o), 0);
    send('0, '0, "R6 threshold");
    chk(mute_o == 1'b1, "R6 8192 mute", int'(mute_o), 1);

    // R8: saturation, no wrap
    quiet_run(9000, "R8 saturate");
    chk(mute_o == 1'b1, "R8 still muted", int'(mute_o), 1);
    // R7: single noisy sample releases
    send(noisy_word(), '0, "R7 release");
    chk(mute_o == 1'b0, "R7 released", int'(mute_o), 0);

    // R9: ratio change clears the run
    quiet_run(8000, "R9 partial run");
    lr_period = 384;
    repeat (5*384) @(negedge clk);
    chk(ratio_ok == 1'b1, "R9 relocked 384", int'(ratio_ok), 1);
    exp_cnt = 0;
    quiet_run(192, "R9 after change");
    chk(mute_o == 1'b0, "R9 count restarted", int'(mute_o), 0);
    quiet_run(RUN - 193, "R9 new run");
    send(ONES, ONES, "R9 new threshold");
    chk(mute_o == 1'b1, "R9 mute after full new run", int'(mute_o), 1);
    send('0, noisy_word(), "R7 right channel release");

    // Random runs around the threshold
    for (int it = 0; it < 4; it++) begin
      int len;
      len = RUN - 2 + int'($urandom % 4);
      quiet_run(len, "R6 random run");
      if ($urandom % 2) send(noisy_word(), quiet_word(), "R7 random release");
      else              send(quiet_word(), noisy_word(), "R7 random release");
    end

    finish_run();
  end

endmodule